// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block sends one serial word on a differential pair of active-low line outputs, using the word shape of MIL-STD-1553. It runs from a single clock at twice the bit rate and puts out a shift clock at the bit rate. Each word is a three-bit-time sync pattern, sixteen Manchester-coded data bits and one odd parity bit. The data bits are not loaded in parallel. The block raises a request strobe, and an external source supplies one bit per shift clock. The source shifts the bits out most significant bit first.

A word starts when the enable input is high at a falling edge of the shift clock. The sync type is then chosen by the select input at the next rising edge: command sync or data sync. If enable stays high through the end of a frame, the next word follows without any gap on the line. An inhibit input forces the line idle and changes nothing else. The active-low reset aborts any word in flight.

Top module: `menc_encoder`

## Requirements
- R1: `shift_clk_o` toggles on every rising edge of `clk_i`. It is low during the first half of each bit period and high during the second half, so its falling edge marks a bit boundary. It is low out of reset.
- R2: A frame starts at a rising `clk_i` edge where `shift_clk_o` is high and `enc_en_i` is high. A frame lasts exactly 20 bit periods, numbered 0 to 19. With enable low and no frame running, nothing starts.
- R3: `sync_sel_i` is sampled once per frame, at the rising shift-clock edge in the middle of period 0. A change at any other time has no effect on that word.
- R4: `data_req_o` is high during frame periods 3 to 18, which is 16 periods. The value on `sdata_i` is captured at each rising shift-clock edge in that window. The first bit captured is the word's most significant bit.
- R5: Data bit j (j=0 is the most significant) goes on the line in frame period 4+j. A one is a positive half-bit (`line_one_no` low) followed by a negative half-bit (`line_zero_no` low). A zero is the reverse.
- R6: The sync occupies frame periods 1 to 3, which is six half-bits. A command sync (select high) is three positive half-bits, then three negative half-bits. A data sync (select low) is three negative, then three positive.
- R7: After the data comes one parity bit, Manchester coded in the same way. It makes the count of ones over the data plus parity odd. It fills the bit period right after frame period 19.
- R8: If enable is high at the end of period 19, the next frame starts at once. The parity bit of the old word fills period 0 of the new frame, so the line has no gap between words.
- R9: While `inh_ni` is low, both line outputs are high. The frame timing, the data capture and the bits that follow are unaffected.
- R10: A low `rst_ni` aborts the word at once. Both line outputs go high, `data_req_o` goes low and `shift_clk_o` goes low. After release, a new word is encoded correctly.
- R11: When no sync, data or parity half-bit is being sent, both line outputs are high. The two outputs are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts transmission |
| enc_en_i | input | 1 | Start request, sampled at shift-clock falling edges |
| sync_sel_i | input | 1 | 1 selects command sync, 0 selects data sync |
| sdata_i | input | 1 | Serial data from the external source |
| inh_ni | input | 1 | Active-low inhibit for both line outputs |
| shift_clk_o | output | 1 | Bit-rate shift clock |
| data_req_o | output | 1 | High while the block wants serial data |
| line_one_no | output | 1 | Active-low positive line drive |
| line_zero_no | output | 1 | Active-low negative line drive |

## Verification
The hardest situation to reach is the seam between two back-to-back words. There, the parity half-bits of one word are sent inside period 0 of the next frame, while the next sync select is being sampled. The bench holds enable high across three frames, so each frame's leading half-bits must carry the previous word's parity. It also flips the select input half a period after each sample point. Separate cases drop the inhibit across the sync-to-data boundary and pull reset in the middle of the data field. These confirm that timing and parity carry on, or restart, as required.

// File: rtl/menc_pkg.sv
package menc_pkg;
  typedef enum logic [1:0] {
    LINE_IDLE = 2'd0,
    LINE_POS  = 2'd1,
    LINE_NEG  = 2'd2
  } line_e;
endpackage

// File: rtl/menc_timing.sv
module menc_timing #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3,
  parameter int SLOT_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              ph_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              par_slot_o,
  output logic              req_o,
  output logic              cap_o,
  output logic              wrap_o,
  output logic              sel_load_o
);
  localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);
  localparam logic [SLOT_W-1:0] REQ_FIRST = SLOT_W'(SYNC_BITS);
  localparam logic [SLOT_W-1:0] REQ_LAST  = SLOT_W'(SYNC_BITS + DATA_W - 1);

  logic              ph_q, busy_q, par_slot_q;
  logic [SLOT_W-1:0] slot_q;
  logic              frame_end;

  assign frame_end = busy_q && (slot_q == LAST_SLOT);

  // ph_q high = second half of bit period; its clearing edge is the shift-clock fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= 1'b0;
      busy_q     <= 1'b0;
      slot_q     <= '0;
      par_slot_q <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        par_slot_q <= frame_end;
        if (busy_q && !frame_end) begin
          slot_q <= slot_q + SLOT_W'(1);
        end else if (en_i) begin
          busy_q <= 1'b1;
          slot_q <= '0;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign ph_o       = ph_q;
  assign busy_o     = busy_q;
  assign slot_o     = slot_q;
  assign par_slot_o = par_slot_q;
  assign req_o      = busy_q && (slot_q >= REQ_FIRST) && (slot_q <= REQ_LAST);
  assign cap_o      = req_o && !ph_q;
  assign wrap_o     = frame_end && ph_q;
  assign sel_load_o = busy_q && (slot_q == '0) && !ph_q;

  AST_FRAME_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && ph_q && en_i) |=> (busy_q && slot_q == '0 && par_slot_q)); // R8
  AST_FRAME_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && ph_q && !en_i) |=> (!busy_q && par_slot_q)); // R2
  AST_SLOT_MIDBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ph_q) |=> $stable(slot_q)); // R1
endmodule

// File: rtl/menc_datapath.sv
module menc_datapath (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdata_i,
  input  logic sync_sel_i,
  input  logic ph_i,
  input  logic cap_i,
  input  logic wrap_i,
  input  logic sel_load_i,
  output logic cmd_o,
  output logic tx_bit_o,
  output logic par_bit_o
);
  logic cmd_q, dat_q, tx_q, par_acc_q, par_tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= 1'b0;
      dat_q     <= 1'b0;
      tx_q      <= 1'b0;
      par_acc_q <= 1'b0;
      par_tx_q  <= 1'b0;
    end else begin
      if (sel_load_i) cmd_q <= sync_sel_i;
      if (cap_i) begin
        dat_q     <= sdata_i;
        par_acc_q <= par_acc_q ^ sdata_i;
      end
      // captured mid-period, sent during the whole next period
      if (ph_i) tx_q <= dat_q;
      if (wrap_i) begin
        par_tx_q  <= ~par_acc_q;
        par_acc_q <= 1'b0;
      end
    end
  end

  assign cmd_o     = cmd_q;
  assign tx_bit_o  = tx_q;
  assign par_bit_o = par_tx_q;

  AST_SEL_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_load_i |=> $stable(cmd_q)); // R3
endmodule

// File: rtl/menc_line.sv
module menc_line
  import menc_pkg::*;
#(
  parameter int SYNC_BITS = 3,
  parameter int SLOT_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ph_i,
  input  logic              busy_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              par_slot_i,
  input  logic              cmd_i,
  input  logic              tx_bit_i,
  input  logic              par_bit_i,
  input  logic              inh_ni,
  output logic              one_no,
  output logic              zero_no
);
  localparam logic [SLOT_W-1:0] SYNC_LAST = SLOT_W'(SYNC_BITS);
  localparam logic [SLOT_W:0]   SYNC_HALF = (SLOT_W+1)'(SYNC_BITS);

  line_e          line;
  logic [SLOT_W:0] half_idx;

  assign half_idx = {slot_i - SLOT_W'(1), ph_i};

  always_comb begin
    line = LINE_IDLE;
    if (par_slot_i) begin
      line = (par_bit_i ^ ph_i) ? LINE_POS : LINE_NEG;
    end else if (busy_i && slot_i >= SLOT_W'(1) && slot_i <= SYNC_LAST) begin
      line = ((half_idx < SYNC_HALF) == cmd_i) ? LINE_POS : LINE_NEG;
    end else if (busy_i && slot_i > SYNC_LAST) begin
      line = (tx_bit_i ^ ph_i) ? LINE_POS : LINE_NEG;
    end
  end

  assign one_no  = !(line == LINE_POS && inh_ni);
  assign zero_no = !(line == LINE_NEG && inh_ni);

  AST_INHIBIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inh_ni |-> (one_no && zero_no)); // R9
  AST_NEVER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_no || zero_no)); // R11
endmodule

// File: rtl/menc_encoder.sv
module menc_encoder #(
  parameter int DATA_W    = 16,
  parameter int SYNC_BITS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enc_en_i,
  input  logic sync_sel_i,
  input  logic sdata_i,
  input  logic inh_ni,
  output logic shift_clk_o,
  output logic data_req_o,
  output logic line_one_no,
  output logic line_zero_no
);
  localparam int FRAME_BITS = SYNC_BITS + DATA_W + 1;
  localparam int SLOT_W     = $clog2(FRAME_BITS);

  logic              ph, busy, par_slot, cap, wrap, sel_load;
  logic              cmd, tx_bit, par_bit;
  logic [SLOT_W-1:0] slot;

  menc_timing #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS), .SLOT_W(SLOT_W)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (enc_en_i),
    .ph_o       (ph),
    .busy_o     (busy),
    .slot_o     (slot),
    .par_slot_o (par_slot),
    .req_o      (data_req_o),
    .cap_o      (cap),
    .wrap_o     (wrap),
    .sel_load_o (sel_load)
  );

  menc_datapath u_datapath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sdata_i    (sdata_i),
    .sync_sel_i (sync_sel_i),
    .ph_i       (ph),
    .cap_i      (cap),
    .wrap_i     (wrap),
    .sel_load_i (sel_load),
    .cmd_o      (cmd),
    .tx_bit_o   (tx_bit),
    .par_bit_o  (par_bit)
  );

  menc_line #(.SYNC_BITS(SYNC_BITS), .SLOT_W(SLOT_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ph_i       (ph),
    .busy_i     (busy),
    .slot_i     (slot),
    .par_slot_i (par_slot),
    .cmd_i      (cmd),
    .tx_bit_i   (tx_bit),
    .par_bit_i  (par_bit),
    .inh_ni     (inh_ni),
    .one_no     (line_one_no),
    .zero_no    (line_zero_no)
  );

  assign shift_clk_o = ph;

  AST_REQ_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_req_o) |-> !shift_clk_o); // R4
endmodule

// File: tb/menc_encoder_bench.sv
module menc_encoder_bench;
  logic clk = 1'b0;
  logic rst_ni, enc_en_i, sync_sel_i, sdata_i, inh_ni;
  logic shift_clk_o, data_req_o, line_one_no, line_zero_no;
  int   checks = 0;
  int   fails  = 0;

  always #5 clk = ~clk;

  menc_encoder u_menc_encoder (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .enc_en_i     (enc_en_i),
    .sync_sel_i   (sync_sel_i),
    .sdata_i      (sdata_i),
    .inh_ni       (inh_ni),
    .shift_clk_o  (shift_clk_o),
    .data_req_o   (data_req_o),
    .line_one_no  (line_one_no),
    .line_zero_no (line_zero_no)
  );

  // {sync_sel, data}
  localparam logic [16:0] VEC [6] = '{17'h1A5C3, 17'h00000, 17'h1FFFF,
                                      17'h08001, 17'h11234, 17'h07FFE};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {one_n, zero_n}; positive half means one_n low
  function automatic logic [1:0] manch(input logic b, input int ph);
    return ((b ^ ph[0]) == 1'b1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] exp_half(input logic sel, input logic [15:0] d, input int k);
    int s = k / 2;
    if (s <= 3) begin
      logic pos = ((k - 2) < 3) == sel;
      return pos ? 2'b01 : 2'b10;
    end
    return manch(d[15 - (s - 4)], k % 2);
  endfunction

  task automatic start_word(input logic sel);
    @(negedge clk); #1;
    if (!shift_clk_o) begin
      @(negedge clk); #1;
    end
    enc_en_i   = 1'b1;
    sync_sel_i = sel;
  endtask

  task automatic run_frame(input logic sel, input logic [15:0] d, input logic hold,
                           input logic lead_v, input logic lead_b,
                           input int inh_from, input int inh_to);
    int err[6], fa[6], fe[6];
    for (int r = 0; r < 6; r++) begin err[r] = 0; fa[r] = 0; fe[r] = 0; end
    for (int k = 0; k < 40; k++) begin
      logic [1:0] got, exp;
      int reg_id;
      logic exp_req;
      @(negedge clk);
      inh_ni = !(k >= inh_from && k <= inh_to);
      if (k == 0) begin sync_sel_i = sel; enc_en_i = hold; end
      if (k == 1) sync_sel_i = ~sel;
      if (k % 2 == 0 && k / 2 >= 3 && k / 2 <= 18) sdata_i = d[15 - (k / 2 - 3)];
      if (k == 39) enc_en_i = hold;
      #1;
      got = {line_one_no, line_zero_no};
      if (!inh_ni) begin reg_id = 3; exp = 2'b11; end
      else if (k < 2) begin reg_id = 0; exp = lead_v ? manch(lead_b, k % 2) : 2'b11; end
      else if (k < 8) begin reg_id = 1; exp = exp_half(sel, d, k); end
      else begin reg_id = 2; exp = exp_half(sel, d, k); end
      if (got !== exp && err[reg_id] == 0) begin fa[reg_id] = int'(got); fe[reg_id] = int'(exp); end
      if (got !== exp) err[reg_id]++;
      exp_req = (k / 2 >= 3) && (k / 2 <= 18);
      if (data_req_o !== exp_req && err[4] == 0) begin fa[4] = int'(data_req_o); fe[4] = int'(exp_req); end
      if (data_req_o !== exp_req) err[4]++;
      if (shift_clk_o !== 1'(k % 2) && err[5] == 0) begin fa[5] = int'(shift_clk_o); fe[5] = k % 2; end
      if (shift_clk_o !== 1'(k % 2)) err[5]++;
    end
    inh_ni = 1'b1;
    check(err[0] == 0, "R7 R8 R11 leading half-bits", fa[0], fe[0]);
    check(err[1] == 0, "R3 R6 sync shape", fa[1], fe[1]);
    check(err[2] == 0, "R5 data half-bits", fa[2], fe[2]);
    if (inh_from >= 0) check(err[3] == 0, "R9 inhibited half-bits", fa[3], fe[3]);
    check(err[4] == 0, "R4 request window", fa[4], fe[4]);
    check(err[5] == 0, "R1 shift clock phase", fa[5], fe[5]);
  endtask

  task automatic tail(input logic pb);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] got, exp;
      @(negedge clk); #1;
      got = {line_one_no, line_zero_no};
      exp = (k < 2) ? manch(pb, k % 2) : 2'b11;
      if (k < 2) check(got === exp, "R7 parity half-bit", int'(got), int'(exp));
      else check(got === exp && !data_req_o, "R2 idle after frame", int'(got), int'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w [3];
    rst_ni = 1'b0; enc_en_i = 1'b0; sync_sel_i = 1'b0; sdata_i = 1'b0; inh_ni = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check({line_one_no, line_zero_no} === 2'b11, "R10 reset line idle",
          int'({line_one_no, line_zero_no}), 3);
    check(data_req_o === 1'b0, "R10 reset request low", int'(data_req_o), 0);
    check(shift_clk_o === 1'b0, "R10 R1 reset shift clock low", int'(shift_clk_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    check(shift_clk_o === 1'b1, "R1 shift clock first toggle", int'(shift_clk_o), 1);
    @(negedge clk); #1;
    check(shift_clk_o === 1'b0, "R1 shift clock second toggle", int'(shift_clk_o), 0);

    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); #1;
        if ({line_one_no, line_zero_no} !== 2'b11 || data_req_o !== 1'b0) bad++;
      end
      check(bad == 0, "R2 R11 no start while enable low", bad, 0);
    end

    // table walk: single words
    for (int i = 0; i < 6; i++) begin
      start_word(VEC[i][16]);
      run_frame(VEC[i][16], VEC[i][15:0], 1'b0, 1'b0, 1'b0, -1, -1);
      tail(~^VEC[i][15:0]);
    end

    // back-to-back words, alternating sync types
    w[0] = 16'hC001; w[1] = 16'h5555; w[2] = 16'h0F0E;
    start_word(1'b1);
    run_frame(1'b1, w[0], 1'b1, 1'b0, 1'b0, -1, -1);
    run_frame(1'b0, w[1], 1'b1, 1'b1, ~^w[0], -1, -1);
    run_frame(1'b1, w[2], 1'b0, 1'b1, ~^w[1], -1, -1);
    tail(~^w[2]);

    // inhibit across sync/data boundary
    start_word(1'b0);
    run_frame(1'b0, 16'h9E37, 1'b0, 1'b0, 1'b0, 4, 13);
    tail(~^16'h9E37);

    // reset in the middle of the data field
    start_word(1'b1);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (k == 0) enc_en_i = 1'b0;
      if (k % 2 == 0) sdata_i = 1'b1;
    end
    @(negedge clk); rst_ni = 1'b0; #1;
    check({line_one_no, line_zero_no} === 2'b11 && !data_req_o && !shift_clk_o,
          "R10 abort clears outputs", int'({line_one_no, line_zero_no}), 3);
    @(negedge clk); rst_ni = 1'b1;
    start_word(1'b0);
    run_frame(1'b0, 16'h6B2D, 1'b0, 1'b0, 1'b0, -1, -1);
    tail(~^16'h6B2D);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule